// File: doc/BRIEF.md
# Predicated Vector AND Reduction Unit

This unit collapses one wide vector operand into a single scalar. The vector is split into lanes of 8, 16, 32 or 64 bits, and a 2-bit size code chosen per operation sets the lane width. A byte-granular predicate marks which lanes take part. The result is the bitwise AND of every participating lane. Lanes that do not take part act as all-ones identities. The result sits in the low lane-width bits of a 64-bit scalar, and every bit above it is zero. No condition flags are produced.

Operands enter through a valid/ready handshake. Masking and a log-depth AND tree form the reduction, and a single register stage holds the result. The result appears on a valid/ready output one cycle after the input is accepted, and it stays there until the consumer takes it. A separate combinational decoder checks a 32-bit instruction word against the reduction's opcode pattern. When the word matches, the decoder returns the size code and the three register numbers, so the surrounding pipeline can read the operands.

Top module: `vred_and_unit`

## Requirements
- R1: While reset is asserted and until the internally synchronised reset releases, out_valid is 0. in_ready is 0 while that synchronised reset is active and 1 once the unit is idle after release.
- R2: The result starts from all ones at the lane width. Each active lane is ANDed into it, so the result is the bitwise AND of all active lanes.
- R3: in_size selects the lane width: 00 for 8 bits, 01 for 16, 10 for 32 and 11 for 64. The vector holds VLEN divided by that width lanes, and lane e occupies bits e*width upward.
- R4: in_pred carries one bit per vector byte. Lane e is active exactly when in_pred bit e*(width/8) is 1. The other predicate bits covering that lane have no effect on the result.
- R5: When no lane is active, the result is all ones across the lane width.
- R6: out_data bits at and above the lane width are 0.
- R7: A transfer happens when in_valid and in_ready are both 1. out_valid is 1 on the cycle after the transfer, and out_data then carries that operation's result.
- R8: While out_valid is 1 and out_ready is 0, out_valid and out_data hold their values and in_ready is 0, so new input is not taken.
- R9: With out_ready held at 1, the unit accepts one operation per cycle and returns the results in order, one per cycle.
- R10: insn_match is 1 when insn_word[31:24]=00000100, [21:18]=0110, [17]=1, [16]=0 and [15:13]=001. Any other word gives 0. The base word 0x041A2000 matches.
- R11: The decoder outputs insn_size=insn_word[23:22], insn_pg=insn_word[12:10], insn_zn=insn_word[9:5] and insn_vd=insn_word[4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Unit can accept an operand |
| in_vec | input | VLEN | Vector operand |
| in_pred | input | VLEN/8 | Predicate, one bit per byte |
| in_size | input | 2 | Lane width code |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Scalar result, zero above lane width |
| insn_word | input | 32 | Instruction word to decode |
| insn_match | output | 1 | Word is the reduction opcode |
| insn_size | output | 2 | Decoded lane width code |
| insn_pg | output | 3 | Decoded predicate register |
| insn_zn | output | 5 | Decoded source vector register |
| insn_vd | output | 5 | Decoded destination register |

## Verification
A fault in the masking or in the tree's lane selection shows up at out_data on the cycle after the transfer, as a bit cleared by an inactive lane or a bit missing from an active one. Masks with only leading bits set, or only non-leading bits set, expose a wrong predicate-index choice within that same cycle. A broken valid or stall register shows up at most one cycle later, as a dropped result, a duplicated result, or out_data changing while the consumer is stalled.

// File: rtl/vred_pkg.sv
package vred_pkg;

  localparam int SCALAR_W = 64;

  typedef enum logic [1:0] {
    LANE_B8  = 2'b00,
    LANE_B16 = 2'b01,
    LANE_B32 = 2'b10,
    LANE_B64 = 2'b11
  } lane_sz_e;

  localparam logic [7:0] OPC_HI  = 8'b0000_0100;
  localparam logic [3:0] OPC_MID = 4'b0110;
  localparam logic [1:0] OPC_B17 = 2'b10;
  localparam logic [2:0] OPC_LO  = 3'b001;

endpackage

// File: rtl/vred_lane_mask.sv
module vred_lane_mask #(
  parameter int VLEN = 256
) (
  input  logic [VLEN-1:0]   vec_i,
  input  logic [VLEN/8-1:0] pred_i,
  input  logic [1:0]        size_i,
  output logic [VLEN-1:0]   vec_o
);
  localparam int NBYTE = VLEN / 8;

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    localparam int LEAD16 = (b / 2) * 2;
    localparam int LEAD32 = (b / 4) * 4;
    localparam int LEAD64 = (b / 8) * 8;
    logic act;

    always_comb begin
      unique case (size_i)
        2'b00:   act = pred_i[b];
        2'b01:   act = pred_i[LEAD16];
        2'b10:   act = pred_i[LEAD32];
        default: act = pred_i[LEAD64];
      endcase
    end

    assign vec_o[b*8 +: 8] = vec_i[b*8 +: 8] | {8{~act}};
  end

endmodule

// File: rtl/vred_and_tree.sv
module vred_and_tree #(
  parameter int VLEN = 256
) (
  input  logic [VLEN-1:0] vec_i,
  output logic [7:0]      fold8_o,
  output logic [15:0]     fold16_o,
  output logic [31:0]     fold32_o,
  output logic [63:0]     fold64_o
);
  localparam int LV64  = $clog2(VLEN / 64);
  localparam int NLVL  = LV64 + 3;

  logic [VLEN-1:0] lvl [0:NLVL];

  assign lvl[0] = vec_i;

  for (genvar k = 0; k < NLVL; k++) begin : g_lvl
    localparam int W = VLEN >> k;
    assign lvl[k+1] = {{(VLEN - W/2){1'b1}},
                       lvl[k][W/2-1:0] & lvl[k][W-1:W/2]};
  end

  assign fold64_o = lvl[LV64][63:0];
  assign fold32_o = lvl[LV64+1][31:0];
  assign fold16_o = lvl[LV64+2][15:0];
  assign fold8_o  = lvl[LV64+3][7:0];

endmodule

// File: rtl/vred_insn_decode.sv
module vred_insn_decode
  import vred_pkg::*;
(
  input  logic [31:0] word_i,
  output logic        match_o,
  output logic [1:0]  size_o,
  output logic [2:0]  pg_o,
  output logic [4:0]  zn_o,
  output logic [4:0]  vd_o
);
  always_comb begin
    match_o = (word_i[31:24] == OPC_HI)  &&
              (word_i[21:18] == OPC_MID) &&
              (word_i[17:16] == OPC_B17) &&
              (word_i[15:13] == OPC_LO);
    size_o  = word_i[23:22];
    pg_o    = word_i[12:10];
    zn_o    = word_i[9:5];
    vd_o    = word_i[4:0];
  end

endmodule

// File: rtl/vred_and_unit.sv
module vred_and_unit
  import vred_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [VLEN-1:0]     in_vec,
  input  logic [VLEN/8-1:0]   in_pred,
  input  logic [1:0]          in_size,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SCALAR_W-1:0] out_data,
  input  logic [31:0]         insn_word,
  output logic                insn_match,
  output logic [1:0]          insn_size,
  output logic [2:0]          insn_pg,
  output logic [4:0]          insn_zn,
  output logic [4:0]          insn_vd
);
  logic [1:0]          rst_sync_q;
  logic                rst_s_n;
  logic [VLEN-1:0]     masked;
  logic [7:0]          f8;
  logic [15:0]         f16;
  logic [31:0]         f32;
  logic [63:0]         f64;
  logic [SCALAR_W-1:0] result;
  logic                accept;
  logic                valid_q, valid_d;
  logic [SCALAR_W-1:0] data_q, data_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  vred_lane_mask #(.VLEN(VLEN)) u_mask (
    .vec_i (in_vec),
    .pred_i(in_pred),
    .size_i(in_size),
    .vec_o (masked)
  );

  vred_and_tree #(.VLEN(VLEN)) u_tree (
    .vec_i   (masked),
    .fold8_o (f8),
    .fold16_o(f16),
    .fold32_o(f32),
    .fold64_o(f64)
  );

  vred_insn_decode u_dec (
    .word_i (insn_word),
    .match_o(insn_match),
    .size_o (insn_size),
    .pg_o   (insn_pg),
    .zn_o   (insn_zn),
    .vd_o   (insn_vd)
  );

  always_comb begin
    unique case (lane_sz_e'(in_size))
      LANE_B8:  result = {{(SCALAR_W-8){1'b0}},  f8};
      LANE_B16: result = {{(SCALAR_W-16){1'b0}}, f16};
      LANE_B32: result = {{(SCALAR_W-32){1'b0}}, f32};
      default:  result = f64;
    endcase
  end

  assign in_ready = rst_s_n && (!valid_q || out_ready);
  assign accept   = in_valid && in_ready;

  always_comb begin
    valid_d = valid_q;
    data_d  = data_q;
    if (accept) begin
      valid_d = 1'b1;
      data_d  = result;
    end else if (out_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) valid_q <= 1'b0;
    else          valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    data_q <= '0;
    else if (accept) data_q <= data_d;
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

endmodule

// File: rtl/vred_and_unit_chk.sv
module vred_and_unit_chk #(
  parameter int VLEN = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [VLEN/8-1:0] in_pred,
  input logic [1:0]        in_size,
  input logic              out_valid,
  input logic              out_ready,
  input logic [63:0]       out_data
);
  logic xfer;
  assign xfer = in_valid && in_ready;

  a_r7_valid_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> out_valid);

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r8_no_accept_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r9_drain_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !xfer |=> !out_valid);

  a_r6_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && in_size == 2'b00 |=> out_data[63:8] == 56'd0);

  a_r5_no_active_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && in_pred == '0 && in_size == 2'b11 |=> out_data == 64'hFFFF_FFFF_FFFF_FFFF);

endmodule

bind vred_and_unit vred_and_unit_chk #(.VLEN(VLEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_pred  (in_pred),
  .in_size  (in_size),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/vred_and_unit_test.sv
module vred_and_unit_test;
  localparam int VLEN  = 256;
  localparam int NBYTE = VLEN / 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid, in_ready;
  logic [VLEN-1:0]   in_vec;
  logic [NBYTE-1:0]  in_pred;
  logic [1:0]        in_size;
  logic              out_valid, out_ready;
  logic [63:0]       out_data;
  logic [31:0]       insn_word;
  logic              insn_match;
  logic [1:0]        insn_size;
  logic [2:0]        insn_pg;
  logic [4:0]        insn_zn, insn_vd;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  vred_and_unit #(.VLEN(VLEN)) uut (.*);

  always #4 clk = ~clk;

  function automatic logic [63:0] ref_and(logic [VLEN-1:0] v, logic [NBYTE-1:0] p, logic [1:0] s);
    int eb = 1 << s;
    logic [63:0] r = (s == 2'b11) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8*eb)) - 64'd1);
    for (int e = 0; e < NBYTE / eb; e++)
      if (p[e*eb])
        for (int j = 0; j < eb; j++)
          r[j*8 +: 8] = r[j*8 +: 8] & v[(e*eb+j)*8 +: 8];
    return r;
  endfunction

  function automatic logic [VLEN-1:0] rand_vec(int sparsity);
    logic [VLEN-1:0] v;
    for (int w = 0; w < VLEN / 32; w++) begin
      logic [31:0] z = '1;
      for (int k = 0; k < sparsity; k++) z = z & $urandom();
      v[w*32 +: 32] = ~z;
    end
    return v;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  task automatic one_op(string req, logic [VLEN-1:0] v, logic [NBYTE-1:0] p, logic [1:0] s);
    @(negedge clk);
    in_valid = 1'b1; in_vec = v; in_pred = p; in_size = s; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R7 valid"}, {63'd0, out_valid}, 64'd1);
    check(req, out_data, ref_and(v, p, s));
    @(negedge clk);
    check({req, " R9 drained"}, {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_vec = '0; in_pred = '0; in_size = 2'b00; insn_word = '0;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R1 in_ready in reset", {63'd0, in_ready}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 out_valid after release", {63'd0, out_valid}, 64'd0);
    check("R1 in_ready after release", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_sizes();
    for (int s = 0; s < 4; s++) begin
      logic [VLEN-1:0] v = rand_vec(3);
      one_op("R2 R3 all active", v, '1, 2'(s));
      one_op("R2 R6 random mask", v, NBYTE'($urandom()), 2'(s));
      one_op("R5 no active", v, '0, 2'(s));
    end
  endtask

  task automatic t_pred_index();
    logic [VLEN-1:0] v = '0;
    logic [NBYTE-1:0] odd = '0;
    logic [NBYTE-1:0] lead = '0;
    for (int b = 0; b < NBYTE; b++) if (b % 8 != 0) odd[b] = 1'b1;
    for (int b = 0; b < NBYTE; b += 8) lead[b] = 1'b1;
    one_op("R4 non-leading bits ignored 64", v, odd, 2'b11);
    check("R4 all-ones expected", out_data, 64'hFFFF_FFFF_FFFF_FFFF);
    v = rand_vec(2);
    one_op("R4 leading bits only 64", v, lead, 2'b11);
    one_op("R4 leading bits at 16", v, lead, 2'b01);
    v = '1; v[8*3 +: 8] = 8'h0F;
    one_op("R4 lane3 inactive bytes", v, NBYTE'(32'h0000_0007), 2'b00);
    check("R4 lane3 value", out_data, 64'h0000_0000_0000_00FF);
  endtask

  task automatic t_stall();
    logic [VLEN-1:0] v1 = rand_vec(2);
    logic [VLEN-1:0] v2 = rand_vec(4);
    logic [63:0] e1 = ref_and(v1, '1, 2'b10);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_vec = v1; in_pred = '1; in_size = 2'b10;
    @(negedge clk);
    in_vec = v2; in_size = 2'b00;
    check("R8 in_ready low on stall", {63'd0, in_ready}, 64'd0);
    repeat (3) @(negedge clk);
    check("R8 valid held", {63'd0, out_valid}, 64'd1);
    check("R8 data held", out_data, e1);
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check("R8 released", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_stream();
    logic [VLEN-1:0] va [4];
    logic [1:0] sa [4];
    for (int i = 0; i < 4; i++) begin va[i] = rand_vec(2); sa[i] = 2'(i); end
    @(negedge clk);
    out_ready = 1'b1;
    for (int i = 0; i < 5; i++) begin
      if (i > 0) begin
        check("R9 stream valid", {63'd0, out_valid}, 64'd1);
        check("R9 stream order", out_data, ref_and(va[i-1], '1, sa[i-1]));
      end
      if (i < 4) begin
        check("R9 in_ready", {63'd0, in_ready}, 64'd1);
        in_valid = 1'b1; in_vec = va[i]; in_pred = '1; in_size = sa[i];
      end else in_valid = 1'b0;
      @(negedge clk);
    end
    check("R9 stream drained", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_random();
    for (int n = 0; n < 40; n++)
      one_op("R2 random", rand_vec(1 + n % 4), NBYTE'({$urandom(), $urandom()}), 2'($urandom()));
  endtask

  task automatic t_decode();
    logic [31:0] w;
    insn_word = 32'h041A_2000; #1;
    check("R10 base match", {63'd0, insn_match}, 64'd1);
    check("R11 base fields", {44'd0, insn_size, insn_pg, insn_zn, insn_vd}, 64'd0);
    w = 32'h041A_2000 | (32'd2 << 22) | (32'd5 << 10) | (32'd17 << 5) | 32'd9;
    insn_word = w; #1;
    check("R10 fields match", {63'd0, insn_match}, 64'd1);
    check("R11 size", {62'd0, insn_size}, 64'd2);
    check("R11 pg", {61'd0, insn_pg}, 64'd5);
    check("R11 zn", {59'd0, insn_zn}, 64'd17);
    check("R11 vd", {59'd0, insn_vd}, 64'd9);
    insn_word = w ^ 32'h0001_0000; #1;
    check("R10 bit16 mismatch", {63'd0, insn_match}, 64'd0);
    insn_word = w ^ 32'h0000_4000; #1;
    check("R10 bit14 mismatch", {63'd0, insn_match}, 64'd0);
    insn_word = w ^ 32'h0100_0000; #1;
    check("R10 top byte mismatch", {63'd0, insn_match}, 64'd0);
  endtask

  initial begin
    t_reset();
    t_decode();
    t_sizes();
    t_pred_index();
    t_stall();
    t_stream();
    t_random();
    finish_run();
  end

endmodule